// File: doc/BRIEF.md
# Temperature-Indexed Bias and Modulation Lookup

This block turns a signed fixed-point temperature sample into a table position. It then reads a 10-bit drive code for each transmitter channel from two tables, one for laser modulation and one for average-power bias. The tables cover a fixed temperature span in 2°C steps. Readings outside the span are clamped to the first or last entry. The position in use is held in an 8-bit index register that the surrounding logic can read.

A host fills the tables through a register-style write port that selects a channel, a table, an entry and a data word. Each pulse on the temperature-ready input latches a new index. The next cycle, all drive outputs are reloaded from the tables at that index. Between samples the outputs hold, so table edits take effect only at the next sample.

Top module: `tlut_ctrl`

## Requirements
- R1: After reset the index register reads 0, every drive output reads 0 and every table entry holds 0.
- R2: For a temperature T inside the span (raw value from -10240 to 26623, LSB 1/256°C, two's complement), the index becomes floor((T + 40°C) / 2°C). A fractional part inside a bin is rounded down.
- R3: A temperature below -40°C, including the most negative raw value -32768, gives index 0.
- R4: A temperature at or above +104°C gives index 71. The index never exceeds 71.
- R5: The index register loads on the clock edge that samples the ready pulse and holds at all other times.
- R6: On the edge after the index loads, each channel's modulation output (bits ch*10 +: 10 of `mod_dac_o`) and power output (same slice of `apc_dac_o`) take that channel's table entries at the new index.
- R7: A host write stores `wr_data_i` at entry `wr_idx_i` of channel `wr_ch_i`, in the modulation table when `wr_tbl_i` is 0 and in the power table when it is 1. Drive outputs do not change until the next ready pulse.
- R8: When a host write and a table lookup land on the same entry in the same cycle, the lookup returns the value that was stored before the write. The write still takes effect for later lookups.
- R9: A host write with `wr_idx_i` of 72 or above changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_i | input | 16 | Signed temperature, 1/256°C per LSB |
| temp_rdy_i | input | 1 | One-cycle pulse: new temperature sample |
| wr_en_i | input | 1 | Host table write strobe |
| wr_ch_i | input | 1 | Channel selected for the write |
| wr_tbl_i | input | 1 | Table selected for the write: 0 modulation, 1 power |
| wr_idx_i | input | 8 | Entry number for the write |
| wr_data_i | input | 10 | Drive code to store |
| index_o | output | 8 | Current table index |
| mod_dac_o | output | 20 | Modulation drive codes, 10 bits per channel |
| apc_dac_o | output | 20 | Power-control drive codes, 10 bits per channel |

## Verification
A table lookup and a host write can hit the same entry in the same cycle. The lookup runs on the edge after a ready pulse, and the host may be rewriting the entry the new index points to at that moment. The bench provokes this by sending a sample and then, in the following cycle, writing a new code to that very entry. It expects the output to show the previous code. A second sample at the same temperature must then bring out the new code.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
  // Table selector used on the host write port
  typedef enum logic {
    TBL_MOD = 1'b0,
    TBL_APC = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/tlut_quant.sv
// Temperature to table-index quantizer with clamping at both ends.
module tlut_quant #(
  parameter int TEMP_W      = 16,
  parameter int FRAC_W      = 8,
  parameter int BIN_LOG2    = 1,
  parameter int TMIN_DEG    = -40,
  parameter int NUM_ENTRIES = 72,
  parameter int IDX_W       = 8
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SUM_W = TEMP_W + 2;
  localparam int SHIFT = FRAC_W + BIN_LOG2;
  localparam int OFFS  = -TMIN_DEG * (2 ** FRAC_W);
  localparam logic [SUM_W-1:0] LAST = SUM_W'(NUM_ENTRIES - 1);

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] bin;

  always_comb begin
    // shift the span start to zero, then drop fraction and bin-width bits
    sum = {{2{temp_i[TEMP_W-1]}}, temp_i} + SUM_W'(OFFS);
    bin = sum >> SHIFT;
    if (sum[SUM_W-1]) begin
      idx_o = '0;
    end else if (bin > LAST) begin
      idx_o = IDX_W'(NUM_ENTRIES - 1);
    end else begin
      idx_o = IDX_W'(bin);
    end
  end
endmodule

// File: rtl/tlut_bank.sv
// One table of drive codes plus its output register.
// The lookup reads the stored contents before any same-cycle write.
module tlut_bank #(
  parameter int ENTRIES = 72,
  parameter int DAC_W   = 10,
  parameter int IDX_W   = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DAC_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [DAC_W-1:0] dac_o
);
  logic [DAC_W-1:0] mem_q [ENTRIES];
  logic [DAC_W-1:0] mem_d [ENTRIES];
  logic [DAC_W-1:0] dac_q, dac_d;
  logic             wr_hit;

  assign wr_hit = wr_en_i && (wr_idx_i < IDX_W'(ENTRIES));

  always_comb begin
    mem_d = mem_q;
    if (wr_hit) begin
      mem_d[wr_idx_i[AW-1:0]] = wr_data_i;
    end
  end

  always_comb begin
    dac_d = dac_q;
    if (rd_en_i) begin
      dac_d = mem_q[rd_idx_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem_q[i] <= '0;
      end
    end else if (wr_hit) begin
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else if (rd_en_i) begin
      dac_q <= dac_d;
    end
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/tlut_ctrl.sv
// Temperature-indexed lookup controller, per-channel modulation and power tables.
module tlut_ctrl #(
  parameter int NUM_CH      = 2,
  parameter int TEMP_W      = 16,
  parameter int FRAC_W      = 8,
  parameter int BIN_LOG2    = 1,
  parameter int TMIN_DEG    = -40,
  parameter int NUM_ENTRIES = 72,
  parameter int IDX_W       = 8,
  parameter int DAC_W       = 10,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW         = $clog2(NUM_ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TEMP_W-1:0]       temp_i,
  input  logic                    temp_rdy_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic                    wr_tbl_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [DAC_W-1:0]        wr_data_i,
  output logic [IDX_W-1:0]        index_o,
  output logic [NUM_CH*DAC_W-1:0] mod_dac_o,
  output logic [NUM_CH*DAC_W-1:0] apc_dac_o
);
  import tlut_pkg::*;

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [IDX_W-1:0] idx_new, idx_q, idx_d;
  logic             lookup_q, lookup_d;

  tlut_quant #(
    .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .BIN_LOG2(BIN_LOG2),
    .TMIN_DEG(TMIN_DEG), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
  ) u_quant (
    .temp_i (temp_i),
    .idx_o  (idx_new)
  );

  always_comb begin
    idx_d    = temp_rdy_i ? idx_new : idx_q;
    lookup_d = temp_rdy_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
    end else if (temp_rdy_i) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lookup_q <= 1'b0;
    end else begin
      lookup_q <= lookup_d;
    end
  end

  assign index_o = idx_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar tb = 0; tb < 2; tb++) begin : g_tbl
      logic             bank_wr;
      logic [DAC_W-1:0] bank_dac;

      assign bank_wr = wr_en_i && (wr_ch_i == CH_W'(ch)) &&
                       (wr_tbl_i == ((tb == 0) ? TBL_MOD : TBL_APC));

      tlut_bank #(
        .ENTRIES(NUM_ENTRIES), .DAC_W(DAC_W), .IDX_W(IDX_W)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .wr_en_i   (bank_wr),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (lookup_q),
        .rd_idx_i  (idx_q[AW-1:0]),
        .dac_o     (bank_dac)
      );

      if (tb == 0) begin : g_mod
        assign mod_dac_o[ch*DAC_W +: DAC_W] = bank_dac;
      end else begin : g_apc
        assign apc_dac_o[ch*DAC_W +: DAC_W] = bank_dac;
      end
    end
  end
endmodule

// File: rtl/tlut_ctrl_chk.sv
// Property checker attached to tlut_ctrl.
module tlut_ctrl_chk #(
  parameter int NUM_CH      = 2,
  parameter int TEMP_W      = 16,
  parameter int FRAC_W      = 8,
  parameter int BIN_LOG2    = 1,
  parameter int TMIN_DEG    = -40,
  parameter int NUM_ENTRIES = 72,
  parameter int IDX_W       = 8,
  parameter int DAC_W       = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [TEMP_W-1:0]       temp_i,
  input logic                    temp_rdy_i,
  input logic [IDX_W-1:0]        index_o,
  input logic [NUM_CH*DAC_W-1:0] mod_dac_o,
  input logic [NUM_CH*DAC_W-1:0] apc_dac_o
);
  localparam int LO_RAW = TMIN_DEG * (2 ** FRAC_W);
  localparam int HI_RAW = (TMIN_DEG + NUM_ENTRIES * (2 ** BIN_LOG2)) * (2 ** FRAC_W);

  // R4: index never leaves the table
  p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    index_o <= IDX_W'(NUM_ENTRIES - 1));

  // R5: no sample, no index change
  p_index_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_rdy_i |=> $stable(index_o));

  // R7: outputs move only in the cycle that follows an index load
  p_dac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_rdy_i |=> ##1 ($stable(mod_dac_o) && $stable(apc_dac_o)));

  // R3: below the span clamps to the first entry
  p_low_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_rdy_i && (int'($signed(temp_i)) < LO_RAW)) |=> (index_o == '0));

  // R4: above the span clamps to the last entry
  p_high_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_rdy_i && (int'($signed(temp_i)) >= HI_RAW)) |=> (index_o == IDX_W'(NUM_ENTRIES - 1)));
endmodule

bind tlut_ctrl tlut_ctrl_chk #(
  .NUM_CH(NUM_CH), .TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .BIN_LOG2(BIN_LOG2),
  .TMIN_DEG(TMIN_DEG), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .DAC_W(DAC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .temp_i     (temp_i),
  .temp_rdy_i (temp_rdy_i),
  .index_o    (index_o),
  .mod_dac_o  (mod_dac_o),
  .apc_dac_o  (apc_dac_o)
);

// File: tb/tlut_ctrl_test.sv
module tlut_ctrl_test;
  localparam int NCH = 2;
  localparam int DW  = 10;
  localparam int NE  = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   temp_i;
  logic          temp_rdy_i;
  logic          wr_en_i;
  logic [0:0]    wr_ch_i;
  logic          wr_tbl_i;
  logic [7:0]    wr_idx_i;
  logic [DW-1:0] wr_data_i;
  logic [7:0]    index_o;
  logic [NCH*DW-1:0] mod_dac_o, apc_dac_o;

  logic [DW-1:0] mod_m [NCH][NE];
  logic [DW-1:0] apc_m [NCH][NE];
  logic [DW-1:0] cur_mod [NCH];
  logic [DW-1:0] cur_apc [NCH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tlut_ctrl uut (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .temp_rdy_i(temp_rdy_i),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_tbl_i(wr_tbl_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .index_o(index_o),
    .mod_dac_o(mod_dac_o), .apc_dac_o(apc_dac_o)
  );

  function automatic int exp_idx(logic [15:0] t);
    int s;
    s = int'($signed(t)) + 10240;
    if (s < 0) return 0;
    s = s / 512;
    if (s > NE - 1) return NE - 1;
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_dacs(string req);
    for (int ch = 0; ch < NCH; ch++) begin
      chk(mod_dac_o[ch*DW +: DW] == cur_mod[ch], req,
          int'(mod_dac_o[ch*DW +: DW]), int'(cur_mod[ch]));
      chk(apc_dac_o[ch*DW +: DW] == cur_apc[ch], req,
          int'(apc_dac_o[ch*DW +: DW]), int'(cur_apc[ch]));
    end
  endtask

  // strobe one sample, check index next cycle and outputs one cycle later
  task automatic sample(logic [15:0] t, string req);
    int k;
    k = exp_idx(t);
    @(negedge clk);
    temp_i = t;
    temp_rdy_i = 1'b1;
    @(negedge clk);
    temp_rdy_i = 1'b0;
    chk(index_o == 8'(k), req, int'(index_o), k);
    for (int ch = 0; ch < NCH; ch++) begin
      cur_mod[ch] = mod_m[ch][k];
      cur_apc[ch] = apc_m[ch][k];
    end
    @(negedge clk);
    check_dacs({req, "/R6"});
  endtask

  task automatic host_write(int ch, int tb, int idx, logic [DW-1:0] d);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_ch_i   = 1'(ch);
    wr_tbl_i  = 1'(tb);
    wr_idx_i  = 8'(idx);
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (idx < NE) begin
      if (tb == 0) mod_m[ch][idx] = d;
      else         apc_m[ch][idx] = d;
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] t;
    logic [15:0] dir [12];
    void'($urandom(32'd20417));
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NE; e++) begin
        mod_m[c][e] = '0;
        apc_m[c][e] = '0;
      end
      cur_mod[c] = '0;
      cur_apc[c] = '0;
    end
    rst_n = 1'b0; temp_i = '0; temp_rdy_i = 1'b0; wr_en_i = 1'b0;
    wr_ch_i = '0; wr_tbl_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports, tables read back as zero
    chk(index_o == 8'd0, "R1 index", int'(index_o), 0);
    check_dacs("R1 outputs");
    sample(16'(25 * 256), "R1 table clear");

    // fill every table through the host port
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NE; e++) begin
        host_write(c, 0, e, DW'($urandom));
        host_write(c, 1, e, DW'($urandom));
      end
    end
    // R7: writes alone leave the outputs at the last looked-up codes
    check_dacs("R7 no change after writes");

    // directed corners
    dir[0]  = 16'hD800;  // -40.0 C   -> 0 (R2)
    dir[1]  = 16'hD7FF;  // just below -> 0 (R3)
    dir[2]  = 16'h8000;  // most negative -> 0 (R3)
    dir[3]  = 16'hD880;  // -39.5 C -> 0 (R2)
    dir[4]  = 16'hDA00;  // -38.0 C -> 1 (R2)
    dir[5]  = 16'h0000;  // 0 C -> 20 (R2)
    dir[6]  = 16'h1980;  // 25.5 C -> 32 (R2)
    dir[7]  = 16'h65FF;  // 101.99 C -> 70 (R2)
    dir[8]  = 16'h6600;  // 102.0 C -> 71 (R2)
    dir[9]  = 16'h6800;  // 104.0 C -> 71 (R4)
    dir[10] = 16'h7FFF;  // max -> 71 (R4)
    dir[11] = 16'hFFFF;  // -1/256 C -> 19 (R2)
    for (int i = 0; i < 12; i++) begin
      sample(dir[i], "R2/R3/R4 directed");
    end

    // R5: index holds with no strobe while temperature input moves
    @(negedge clk);
    temp_i = 16'h0400;
    repeat (3) @(negedge clk);
    chk(index_o == 8'd19, "R5 hold", int'(index_o), 19);

    // R8: write to the entry being looked up in the same cycle
    sample(16'h1000, "R8 setup");   // 16 C -> index 28
    @(negedge clk);
    temp_i = 16'h1000;
    temp_rdy_i = 1'b1;
    @(negedge clk);
    temp_rdy_i = 1'b0;
    wr_en_i = 1'b1; wr_ch_i = 1'b0; wr_tbl_i = 1'b0;
    wr_idx_i = 8'd28; wr_data_i = ~mod_m[0][28];
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(mod_dac_o[DW-1:0] == mod_m[0][28], "R8 old value on collision",
        int'(mod_dac_o[DW-1:0]), int'(mod_m[0][28]));
    mod_m[0][28] = ~mod_m[0][28];
    sample(16'h1000, "R8 new value next sample");

    // R7: write to the live entry of channel 1 power table, outputs hold
    host_write(1, 1, 28, ~apc_m[1][28]);
    check_dacs("R7 live entry write held");
    sample(16'h1000, "R7 live entry write applied");

    // R9: out-of-range entry writes change nothing
    for (int i = 0; i < 8; i++) begin
      host_write(int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                 int'($urandom_range(72, 255)), DW'($urandom));
    end

    // random samples, biased to the span and over the full range
    for (int i = 0; i < 150; i++) begin
      if (i % 3 == 0) t = 16'($urandom);
      else            t = 16'(int'($urandom_range(0, 38000)) - 11000);
      sample(t, "R2/R3/R4 random");
    end

    // R9 and R6: sweep every entry with a fractional offset inside the bin
    for (int e = 0; e < NE; e++) begin
      t = 16'((-40 + 2 * e) * 256 + int'($urandom_range(0, 511)));
      sample(t, "R9 sweep");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule